// File: doc/BRIEF.md
# Temperature Sensor Read Sequencer

This block is the control layer that sits above a byte-level I2C master and performs one complete temperature read from a digital sensor for each start request. The start request may come from an unrelated clock domain, so it is first brought into the local clock and captured as a pending flag. That flag is what moves the sequencer out of idle. An edge that arrives while a read is in flight is held and then served once the current read is over.

For each read the sequencer presents the sensor's 7-bit address, the register index and a two-byte count to the master, and pulses a go strobe. It then waits for the master to report either completion or a bit error. An error sends it straight back to idle and leaves the output alone. On completion the 16-bit reading, most significant byte first, is turned into a signed integer in units of 10^-4 degrees Celsius. The top 13 bits are a two's-complement count of 1/16 degree, so each count contributes 625 to the result. A plausibility window then drops any result outside -55 to +150 degrees. The sequencer always pulses an acknowledge so the master can return to idle. Only an accepted value reaches the output, and it is marked by a one-cycle valid strobe.

Top module: `tsens_read_seq`

## Requirements
- R1: During and directly after a synchronous active-high reset, cmd_go, done_read and temp_valid are 0 and temp_out is 0.
- R2: A rising edge of start_req is registered at clock edge e0. The sequencer is idle at that point. cmd_go is then high for exactly the one cycle that follows clock edge e0+3.
- R3: Rising edges of start_req that arrive while a read is in progress collapse into a single pending request. That request starts exactly one more read after the sequencer returns to idle.
- R4: cmd_addr is held at 0x4B, cmd_reg at 0x00 and cmd_nbytes at 2 at all times, and cmd_go is never high for two consecutive cycles.
- R5: While the sequencer waits, mst_error high sends it back to idle at the next edge. This holds even when mst_done is high in the same cycle. No done_read pulse follows, and temp_out and temp_valid do not change.
- R6: When mst_done is high during the wait, and mst_error is low, mst_data is captured. done_read is then high for exactly the next cycle.
- R7: The result is the arithmetic value of mst_data[15:3], read as a signed 13-bit number, multiplied by 625. It is accepted only when it lies within -550000 to 1500000, both limits inclusive.
- R8: An accepted result appears on temp_out in the cycle right after done_read, and temp_valid is high for that one cycle. A rejected result leaves temp_out unchanged and temp_valid low. temp_out changes at no other time.
- R9: Holding start_req high starts only one read. A new read needs a new rising edge.
- R10: mst_done and mst_error are ignored while the sequencer is not waiting on the master. They start no read and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start request, asynchronous to clk, acts on its rising edge |
| cmd_addr | output | 7 | Sensor device address for the master |
| cmd_reg | output | 8 | Register index to read |
| cmd_nbytes | output | 2 | Number of bytes to read |
| cmd_go | output | 1 | One-cycle strobe that launches the master transaction |
| mst_done | input | 1 | Master reports a completed read |
| mst_error | input | 1 | Master reports a failed transaction |
| mst_data | input | 16 | Bytes read by the master, first byte in bits 15:8 |
| done_read | output | 1 | One-cycle acknowledge that the response was consumed |
| temp_out | output | 32 | Signed temperature in units of 10^-4 degrees Celsius |
| temp_valid | output | 1 | One-cycle strobe marking a fresh temp_out |

## Verification
Reads are run with raw words that land on each edge of the window and one step past each edge. These tell inclusive limits from exclusive ones and check that negative values keep their sign. A word with nonzero low bits shows whether the three fraction-free bits are discarded. Error responses, with and without a coincident done, separate the error path from the success path. Start edges during a busy read, a start held high, and master strobes while idle test the collapsing, edge-only and ignore rules. Each cycle is compared against a behavioural model.

// File: rtl/tsens_pkg.sv
package tsens_pkg;

    localparam int RAW_W     = 16;
    localparam int DROP_BITS = 3;
    localparam int TEMP_W    = 32;
    localparam int SCALE     = 625;
    localparam int T_MIN     = -550000;
    localparam int T_MAX     = 1500000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic                     ok;
        logic signed [TEMP_W-1:0] value;
    } conv_t;

    function automatic conv_t raw_to_temp(logic [RAW_W-1:0] raw);
        conv_t                    r;
        logic signed [TEMP_W-1:0] ext;
        ext     = $signed({{(TEMP_W-RAW_W){raw[RAW_W-1]}}, raw}) >>> DROP_BITS;
        r.value = ext * SCALE;
        r.ok    = (r.value >= T_MIN) && (r.value <= T_MAX);
        return r;
    endfunction

endpackage

// File: rtl/tsens_start_latch.sv
module tsens_start_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_async,
    input  logic consume,
    output logic pending
);
    localparam int HW = SYNC_STAGES + 1;

    logic [HW-1:0] hist_q;
    logic          rise;

    assign rise = hist_q[SYNC_STAGES-1] & ~hist_q[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '0;
            pending <= 1'b0;
        end else begin
            hist_q <= {hist_q[HW-2:0], start_async};
            if (rise)
                pending <= 1'b1;
            else if (consume)
                pending <= 1'b0;
        end
    end

    // R3: a held request survives until it is consumed
    a_r3_pending_held: assert property (@(posedge clk) disable iff (rst)
        (pending && !consume) |=> pending);

endmodule

// File: rtl/tsens_convert.sv
module tsens_convert
    import tsens_pkg::*;
(
    input  logic [RAW_W-1:0]         raw,
    output logic                     ok,
    output logic signed [TEMP_W-1:0] value
);
    conv_t c;

    always_comb begin
        c     = raw_to_temp(raw);
        ok    = c.ok;
        value = c.value;
    end

endmodule

// File: rtl/tsens_seq_fsm.sv
module tsens_seq_fsm
    import tsens_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pending,
    output logic                     consume,
    output logic                     cmd_go,
    input  logic                     mst_done,
    input  logic                     mst_error,
    input  logic [RAW_W-1:0]         mst_data,
    output logic                     done_read,
    output logic [RAW_W-1:0]         raw_q,
    input  logic                     conv_ok,
    input  logic signed [TEMP_W-1:0] conv_value,
    output logic signed [TEMP_W-1:0] temp_out,
    output logic                     temp_valid
);
    seq_state_e state;

    assign consume   = (state == ST_IDLE) && pending;
    assign cmd_go    = (state == ST_ISSUE);
    assign done_read = (state == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            raw_q      <= '0;
            temp_out   <= '0;
            temp_valid <= 1'b0;
        end else begin
            temp_valid <= 1'b0;
            unique case (state)
                ST_IDLE:  if (pending) state <= ST_ISSUE;
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mst_error) begin
                        state <= ST_IDLE;
                    end else if (mst_done) begin
                        raw_q <= mst_data;
                        state <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                    if (conv_ok) begin
                        temp_out   <= conv_value;
                        temp_valid <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: the launch strobe lasts a single cycle
    a_r4_go_single: assert property (@(posedge clk) disable iff (rst)
        cmd_go |=> !cmd_go);

    // R5: an error while waiting returns to idle without acknowledge
    a_r5_error_to_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && mst_error) |=> (!done_read && !cmd_go && !temp_valid));

    // R8: a fresh value directly follows the acknowledge
    a_r8_valid_after_ack: assert property (@(posedge clk) disable iff (rst)
        temp_valid |-> $past(done_read));

    // R8: the output holds unless marked fresh
    a_r8_hold_output: assert property (@(posedge clk) disable iff (rst)
        !temp_valid |-> $stable(temp_out));

    // R7: published values lie inside the window
    a_r7_in_window: assert property (@(posedge clk) disable iff (rst)
        temp_valid |-> (temp_out >= T_MIN && temp_out <= T_MAX));

endmodule

// File: rtl/tsens_read_seq.sv
module tsens_read_seq
    import tsens_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4B,
    parameter logic [7:0] REG_IDX  = 8'h00,
    parameter int         NBYTES   = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_req,
    output logic [6:0]               cmd_addr,
    output logic [7:0]               cmd_reg,
    output logic [1:0]               cmd_nbytes,
    output logic                     cmd_go,
    input  logic                     mst_done,
    input  logic                     mst_error,
    input  logic [RAW_W-1:0]         mst_data,
    output logic                     done_read,
    output logic signed [TEMP_W-1:0] temp_out,
    output logic                     temp_valid
);
    logic                     pending;
    logic                     consume;
    logic [RAW_W-1:0]         raw_q;
    logic                     conv_ok;
    logic signed [TEMP_W-1:0] conv_value;

    assign cmd_addr   = DEV_ADDR;
    assign cmd_reg    = REG_IDX;
    assign cmd_nbytes = 2'(NBYTES);

    tsens_start_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
        .clk(clk), .rst(rst), .start_async(start_req),
        .consume(consume), .pending(pending)
    );

    tsens_convert u_conv (
        .raw(raw_q), .ok(conv_ok), .value(conv_value)
    );

    tsens_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .pending(pending), .consume(consume),
        .cmd_go(cmd_go), .mst_done(mst_done), .mst_error(mst_error),
        .mst_data(mst_data), .done_read(done_read), .raw_q(raw_q),
        .conv_ok(conv_ok), .conv_value(conv_value),
        .temp_out(temp_out), .temp_valid(temp_valid)
    );

endmodule

// File: tb/tsens_read_seq_test.sv
module tsens_read_seq_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0;
    logic        mst_done = 1'b0;
    logic        mst_error = 1'b0;
    logic [15:0] mst_data = '0;
    logic [6:0]  cmd_addr;
    logic [7:0]  cmd_reg;
    logic [1:0]  cmd_nbytes;
    logic        cmd_go;
    logic        done_read;
    logic signed [31:0] temp_out;
    logic        temp_valid;

    int compared = 0;
    int mismatched = 0;
    int go_count = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsens_read_seq uut (
        .clk(clk), .rst(rst), .start_req(start_req),
        .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_nbytes(cmd_nbytes),
        .cmd_go(cmd_go), .mst_done(mst_done), .mst_error(mst_error),
        .mst_data(mst_data), .done_read(done_read),
        .temp_out(temp_out), .temp_valid(temp_valid)
    );

    // behavioural reference: start history, pending request, read phase
    int          m_phase;   // 0 idle, 1 launching, 2 waiting, 3 acknowledging
    bit   [2:0]  m_hist;
    bit          m_pend;
    bit   [15:0] m_raw;
    int          m_temp;
    bit          m_vld;

    function automatic int scaled(bit [15:0] w);
        int code;
        code = int'(w) / 8;
        if (code >= 4096) code = code - 8192;
        return code * 625;
    endfunction

    always @(posedge clk) begin
        int v;
        if (rst) begin
            m_phase <= 0; m_hist <= '0; m_pend <= 0;
            m_raw <= '0; m_temp <= 0; m_vld <= 0;
        end else begin
            m_hist <= {m_hist[1:0], start_req};
            if (m_hist[1] && !m_hist[2]) m_pend <= 1;
            else if (m_phase == 0) m_pend <= 0;
            m_vld <= 0;
            if (m_phase == 0) begin
                if (m_pend) m_phase <= 1;
            end else if (m_phase == 1) begin
                m_phase <= 2;
            end else if (m_phase == 2) begin
                if (mst_error) m_phase <= 0;
                else if (mst_done) begin m_raw <= mst_data; m_phase <= 3; end
            end else begin
                m_phase <= 0;
                v = scaled(m_raw);
                if (v >= -550000 && v <= 1500000) begin
                    m_temp <= v; m_vld <= 1;
                end
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("R2 cmd_go", int'(cmd_go), int'(m_phase == 1));
            check("R6 done_read", int'(done_read), int'(m_phase == 3));
            check("R8 temp_valid", int'(temp_valid), int'(m_vld));
            check("R7 temp_out", temp_out, m_temp);
            check("R4 cmd fields", {cmd_addr, cmd_reg, 6'(cmd_nbytes)},
                  {7'h4B, 8'h00, 6'd2});
            if (cmd_go) go_count++;
        end
    end

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_req = 1'b1; ticks(2); start_req = 1'b0;
    endtask

    task automatic wait_go();
        int guard = 0;
        while (!cmd_go && guard < 50) begin @(negedge clk); guard++; end
    endtask

    task automatic respond(bit [15:0] w, bit err, bit dn, int dly);
        ticks(dly);
        mst_data = w; mst_error = err; mst_done = dn;
        ticks(1);
        mst_error = 0; mst_done = 0;
    endtask

    task automatic full_read(bit [15:0] w, bit err, bit dn, int dly);
        pulse_start(); wait_go(); ticks(1); respond(w, err, dn, dly); ticks(4);
    endtask

    initial begin
        while (cycles < 100000) begin @(posedge clk); cycles++; end
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int g0;
        ticks(3);
        check("R1 reset cmd_go", int'(cmd_go), 0);
        check("R1 reset temp_out", temp_out, 0);
        check("R1 reset temp_valid", int'(temp_valid), 0);
        rst = 0;
        ticks(2);
        check("R1 after reset done_read", int'(done_read), 0);

        // R2 latency: rise before edge e0, go after e0+3
        @(negedge clk); start_req = 1;
        @(negedge clk);                 // e0 passed
        ticks(2); start_req = 0;        // e1, e2 passed
        check("R2 go not early", int'(cmd_go), 0);
        ticks(1);                       // e3 passed
        check("R2 go on time", int'(cmd_go), 1);
        ticks(1); respond(16'h0CD0, 0, 1, 2); ticks(4);
        check("R7 25.625 degrees", temp_out, 256250);

        full_read(16'h0CD7, 0, 1, 1);   // R7: low bits discarded
        check("R7 low bits dropped", temp_out, 256250);
        full_read(16'h4B00, 0, 1, 3);
        check("R7 upper limit kept", temp_out, 1500000);
        full_read(16'h4B08, 0, 1, 0);
        check("R7 above limit dropped", temp_out, 1500000);
        full_read(16'hE480, 0, 1, 2);
        check("R7 lower limit kept", temp_out, -550000);
        full_read(16'hE478, 0, 1, 2);
        check("R7 below limit dropped", temp_out, -550000);
        full_read(16'h0000, 0, 1, 1);
        check("R6 zero reading", temp_out, 0);
        full_read(16'h0CD0, 1, 0, 2);
        check("R5 error keeps output", temp_out, 0);
        full_read(16'h0CD0, 1, 1, 2);
        check("R5 error wins over done", temp_out, 0);

        // R10: master strobes while idle
        g0 = go_count;
        respond(16'h1230, 0, 1, 0); respond(16'h1230, 1, 0, 0); ticks(6);
        check("R10 idle strobes ignored go", go_count - g0, 0);
        check("R10 idle strobes ignored temp", temp_out, 0);

        // R3: two edges during a busy read -> one more read
        g0 = go_count;
        pulse_start(); wait_go(); ticks(2);
        pulse_start(); ticks(2); pulse_start(); ticks(3);
        respond(16'h0190, 0, 1, 0);
        wait_go(); ticks(1); respond(16'h0320, 0, 1, 1); ticks(10);
        check("R3 collapsed requests", go_count - g0, 2);
        check("R3 second read value", temp_out, 62500);

        // R9: held start only launches once
        g0 = go_count;
        start_req = 1; wait_go(); ticks(1); respond(16'h0190, 0, 1, 1);
        ticks(12); start_req = 0; ticks(6);
        check("R9 level start once", go_count - g0, 1);
        check("R9 value", temp_out, 31250);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule